// File: doc/BRIEF.md
# DC-Balanced Video/Control Word Framer

This block turns a stream of parallel pixel samples into 20-bit line words and a serial bit stream. Each sample carries 18 video bits, 9 control bits and a data-enable flag. When the flag is high the video bits are sent with two overhead bits. When it is low the control bits are spread across 19 positions, some of them repeated so that a receiver can take a majority vote, and sent with one overhead bit. An overhead bit tells the receiver whether the payload was inverted. A running-disparity tally decides each inversion, so the line stays DC-balanced.

The word rate comes from a bit-rate enable. Every 20th enable pulse is a word boundary. At that boundary the inputs are captured, a new word is loaded and its bits then leave least significant bit first. A two-word delay line lets the block see the data-enable flag two words ahead. It uses this to put a fixed marker word in the control slot next to each video run. It also uses it to stop sampling the control inputs near video, because the marker words take the place of control data there.

Top module: `dcb_word_framer`

## Requirements
- R1: A video word carries the video bits in bits [19:2], bit 0 is the inversion flag and bit 1 is its complement; when bit 0 is 1, bits [19:2] hold the inverted video bits.
- R2: A control word has the inversion flag in bit 0. Control bit i (i = 0..4) fills bits 3i+1 to 3i+3, and control bit i (i = 5..8) fills bit i+11. When bit 0 is 1, bits [19:1] are inverted.
- R3: Let D be the sum, over all words emitted since reset, of (2 x ones - 20). A data word is inverted exactly when D and the word's own uninverted disparity are both nonzero and have the same sign. D stays within -20..20.
- R4: The last control slot before a video run carries 20'hF1E84, and the first control slot after a video run carries 20'h0F0FC. A single control slot between two video runs carries 20'hF1E84.
- R5: A control word uses its own slot's control inputs only when data enable is low in that slot, in the two slots before it and in the two slots after it. Otherwise it repeats the last sampled control value, which is 0 after reset.
- R6: The inputs captured at word boundary k appear on word_out from boundary k+2 onward, and word_out changes only at a boundary.
- R7: ser_out gives word bits 0 to 19 in order, advancing one bit per bit_en pulse. word_start is high exactly during the bit 0 period. The outputs hold while bit_en is low.
- R8: Reset clears word_out, ser_out, word_start, the delay line, the held control value and the disparity, and makes the next bit_en pulse a word boundary.
- R9: Inputs are captured only at a word boundary; changes between boundaries have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; every 20th pulse is a word boundary |
| de_in | input | 1 | Data enable: 1 selects video, 0 selects control |
| vid_in | input | 18 | Video bits |
| ctl_in | input | 9 | Control bits |
| word_out | output | 20 | Word being serialized |
| ser_out | output | 1 | Serial bit, LSB first |
| word_start | output | 1 | High during bit 0 of each word |

## Verification
The stimulus includes long control runs, a single control slot between two video runs and a single-slot video run. A design that got the guard window wrong would sample control values it should hold. A design that ordered the two marker words wrongly would send the closing marker where the opening one belongs. The input patterns include all-ones and all-zero payloads, which push the disparity tally to its limits. A design that inverted on the wrong sign, or failed to clear the tally at reset, would emit words other than the expected ones. Inputs are scrambled between boundaries, so a framer that sampled outside a boundary would corrupt the words it sends.

// File: rtl/dcbf_pkg.sv
package dcbf_pkg;
    localparam int VID_W    = 18;
    localparam int CTL_W    = 9;
    localparam int TRIP_N   = 5;
    localparam int TRIP_REP = 3;
    localparam int MAP_W    = TRIP_N * TRIP_REP + (CTL_W - TRIP_N);
    localparam int WORD_W   = VID_W + 2;
    localparam int CNT_W    = $clog2(WORD_W);
    localparam int DISP_W   = $clog2(WORD_W) + 2;

    // Fixed boundary markers: ten ones each, bits[1:0]=00 and bits[3:1] not uniform.
    localparam logic [WORD_W-1:0] MARK_OPEN  = 20'hF1E84;
    localparam logic [WORD_W-1:0] MARK_CLOSE = 20'h0F0FC;

    typedef enum logic [1:0] {
        K_CTL   = 2'd0,
        K_VID   = 2'd1,
        K_OPEN  = 2'd2,
        K_CLOSE = 2'd3
    } wkind_e;

    typedef struct packed {
        logic             de;
        logic [VID_W-1:0] vid;
        logic [CTL_W-1:0] ctl;
    } px_t;

    function automatic logic signed [DISP_W-1:0] word_disp(input logic [WORD_W-1:0] w);
        int n;
        n = 0;
        for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
        return DISP_W'(2 * n - WORD_W);
    endfunction
endpackage

// File: rtl/dcbf_delay.sv
module dcbf_delay
    import dcbf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  px_t  in_px,
    output px_t  cur,
    output logic nxt_de,
    output logic prev1_de,
    output logic prev2_de
);
    px_t stage1;
    px_t stage2;
    logic p1, p2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            p1     <= 1'b0;
            p2     <= 1'b0;
        end else if (tick) begin
            stage1 <= in_px;
            stage2 <= stage1;
            p1     <= stage2.de;
            p2     <= p1;
        end
    end

    assign cur      = stage2;
    assign nxt_de   = stage1.de;
    assign prev1_de = p1;
    assign prev2_de = p2;
endmodule

// File: rtl/dcbf_ctl_map.sv
module dcbf_ctl_map
    import dcbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             take,
    input  logic [CTL_W-1:0] ctl_now,
    output logic [MAP_W-1:0] mapped
);
    logic [CTL_W-1:0] held;
    logic [CTL_W-1:0] eff;

    assign eff = take ? ctl_now : held;

    always_ff @(posedge clk) begin
        if (rst)               held <= '0;
        else if (tick && take) held <= ctl_now;
    end

    for (genvar i = 0; i < TRIP_N; i++) begin : g_trip
        assign mapped[i*TRIP_REP +: TRIP_REP] = {TRIP_REP{eff[i]}};
    end
    for (genvar i = TRIP_N; i < CTL_W; i++) begin : g_single
        assign mapped[TRIP_N*TRIP_REP + (i - TRIP_N)] = eff[i];
    end
endmodule

// File: rtl/dcbf_balance.sv
module dcbf_balance
    import dcbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  wkind_e            kind,
    input  logic [VID_W-1:0]  vid,
    input  logic [MAP_W-1:0]  mapped,
    output logic [WORD_W-1:0] enc
);
    logic signed [DISP_W-1:0] rd;
    logic signed [DISP_W-1:0] d;
    logic signed [DISP_W-1:0] step;
    logic [WORD_W-1:0] raw;
    logic inv;

    always_comb begin
        unique case (kind)
            K_VID:   raw = {vid, 1'b1, 1'b0};
            K_CTL:   raw = {mapped, 1'b0};
            K_OPEN:  raw = MARK_OPEN;
            default: raw = MARK_CLOSE;
        endcase
        d    = word_disp(raw);
        inv  = ((kind == K_VID) || (kind == K_CTL)) && (rd != '0) && (d != '0)
               && (rd[DISP_W-1] == d[DISP_W-1]);
        enc  = inv ? ~raw : raw;
        step = inv ? -d : d;
    end

    always_ff @(posedge clk) begin
        if (rst)       rd <= '0;
        else if (tick) rd <= rd + step;
    end
endmodule

// File: rtl/dcbf_shift.sv
module dcbf_shift
    import dcbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] enc,
    output logic              tick,
    output logic [WORD_W-1:0] word_out,
    output logic              ser_out,
    output logic              word_start
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;

    assign tick = bit_en && (bit_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= LAST;
            shreg    <= '0;
            word_out <= '0;
        end else if (tick) begin
            bit_cnt  <= '0;
            shreg    <= enc;
            word_out <= enc;
        end else if (bit_en) begin
            bit_cnt  <= bit_cnt + 1'b1;
            shreg    <= {1'b0, shreg[WORD_W-1:1]};
        end
    end

    assign ser_out    = shreg[0];
    assign word_start = (bit_cnt == '0);
endmodule

// File: rtl/dcb_word_framer.sv
module dcb_word_framer
    import dcbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              de_in,
    input  logic [VID_W-1:0]  vid_in,
    input  logic [CTL_W-1:0]  ctl_in,
    output logic [WORD_W-1:0] word_out,
    output logic              ser_out,
    output logic              word_start
);
    logic tick;
    px_t  in_px, cur;
    logic nxt_de, prev1_de, prev2_de;
    logic take;
    wkind_e kind;
    logic [MAP_W-1:0]  mapped;
    logic [WORD_W-1:0] enc;

    assign in_px = {de_in, vid_in, ctl_in};

    dcbf_delay u_delay (
        .clk(clk), .rst(rst), .tick(tick), .in_px(in_px),
        .cur(cur), .nxt_de(nxt_de), .prev1_de(prev1_de), .prev2_de(prev2_de)
    );

    // Guard window: two slots either side of any video slot.
    assign take = !(cur.de | nxt_de | de_in | prev1_de | prev2_de);

    always_comb begin
        if (cur.de)        kind = K_VID;
        else if (nxt_de)   kind = K_OPEN;
        else if (prev1_de) kind = K_CLOSE;
        else               kind = K_CTL;
    end

    dcbf_ctl_map u_map (
        .clk(clk), .rst(rst), .tick(tick), .take(take),
        .ctl_now(cur.ctl), .mapped(mapped)
    );

    dcbf_balance u_bal (
        .clk(clk), .rst(rst), .tick(tick), .kind(kind),
        .vid(cur.vid), .mapped(mapped), .enc(enc)
    );

    dcbf_shift u_shift (
        .clk(clk), .rst(rst), .bit_en(bit_en), .enc(enc), .tick(tick),
        .word_out(word_out), .ser_out(ser_out), .word_start(word_start)
    );
endmodule

// File: rtl/dcb_word_framer_chk.sv
module dcb_word_framer_chk
    import dcbf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic [WORD_W-1:0] word_out,
    input logic              ser_out,
    input logic              word_start
);
    logic live;
    logic ws_d;
    logic signed [DISP_W:0] rd_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
            ws_d <= 1'b0;
            rd_c <= '0;
        end else begin
            live <= 1'b1;
            ws_d <= word_start;
            if (word_start && !ws_d)
                rd_c <= rd_c + (DISP_W+1)'(word_disp(word_out));
        end
    end

    // R7: nothing moves without a bit enable
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(word_out) && $stable(ser_out) && $stable(word_start)));

    // R7: first serial bit of a word is its LSB
    assert_bit0_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(word_start) |-> (ser_out == word_out[0]));

    // R6: word_out only changes at a word boundary
    assert_change_at_start_R6: assert property (@(posedge clk) disable iff (rst)
        (live && !$stable(word_out)) |-> word_start);

    // R4: every word is a video word, a control word or one of the markers
    assert_legal_word_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(word_start) |-> ((word_out[1] != word_out[0])
                              || (word_out[3:1] == 3'b000) || (word_out[3:1] == 3'b111)
                              || (word_out == MARK_OPEN) || (word_out == MARK_CLOSE)));

    // R3: running disparity bounded
    assert_disp_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_c <= 20) && (rd_c >= -20));
endmodule

bind dcb_word_framer dcb_word_framer_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .word_out(word_out),
    .ser_out(ser_out), .word_start(word_start)
);

// File: tb/tb_dcb_word_framer.sv
module tb_dcb_word_framer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;
    localparam int NS = NV + 4;

    // {de, vid[17:0], ctl[8:0]}
    localparam logic [27:0] VEC [0:NV-1] = '{
        {1'b0, 18'h00000, 9'h1FF}, {1'b0, 18'h00000, 9'h155},
        {1'b0, 18'h00000, 9'h0AA}, {1'b0, 18'h00000, 9'h013},
        {1'b0, 18'h00000, 9'h1E7}, {1'b0, 18'h00000, 9'h0F0},
        {1'b0, 18'h00000, 9'h123}, {1'b0, 18'h00000, 9'h0C3},
        {1'b1, 18'h3FFFF, 9'h1FF}, {1'b1, 18'h00001, 9'h000},
        {1'b1, 18'h2AAAA, 9'h000}, {1'b1, 18'h12345, 9'h000},
        {1'b0, 18'h00000, 9'h111}, {1'b1, 18'h3F00F, 9'h000},
        {1'b1, 18'h00000, 9'h000}, {1'b0, 18'h00000, 9'h1AB},
        {1'b0, 18'h00000, 9'h07E}, {1'b0, 18'h00000, 9'h0E1},
        {1'b0, 18'h00000, 9'h19C}, {1'b0, 18'h00000, 9'h155},
        {1'b1, 18'h3FFFF, 9'h000}, {1'b0, 18'h00000, 9'h0AA},
        {1'b0, 18'h00000, 9'h1C7}, {1'b0, 18'h00000, 9'h038}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic de_in = 1'b0;
    logic [17:0] vid_in = '0;
    logic [8:0]  ctl_in = '0;
    logic [19:0] word_out;
    logic ser_out, word_start;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [19:0] exp_w [0:NS-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcb_word_framer dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .de_in(de_in), .vid_in(vid_in),
        .ctl_in(ctl_in), .word_out(word_out), .ser_out(ser_out), .word_start(word_start)
    );

    task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic dev(input int i);
        if (i < 0 || i >= NV) return 1'b0;
        return VEC[i][27];
    endfunction

    function automatic logic [19:0] map_ctl(input logic [8:0] c);
        logic [19:0] r = '0;
        for (int i = 0; i < 5; i++) r[3*i+1 +: 3] = {3{c[i]}};
        for (int i = 5; i < 9; i++) r[i+11] = c[i];
        return r;
    endfunction

    function automatic int ones(input logic [19:0] w);
        int n = 0;
        for (int i = 0; i < 20; i++) n += int'(w[i]);
        return n;
    endfunction

    // Reference words per slot, from R1..R5 (slot j shows input j-2, R6)
    task automatic build_expected();
        int rd = 0;
        logic [8:0] held = '0;
        for (int j = 0; j < NS; j++) begin
            int k = j - 2;
            logic [19:0] raw;
            logic [17:0] v;
            logic [8:0] c;
            bit data;
            int d;
            v = (k >= 0 && k < NV) ? VEC[k][26:9] : '0;
            c = (k >= 0 && k < NV) ? VEC[k][8:0] : '0;
            data = 1'b1;
            if (dev(k)) raw = {v, 2'b10};
            else if (dev(k+1)) begin raw = 20'hF1E84; data = 1'b0; end
            else if (dev(k-1)) begin raw = 20'h0F0FC; data = 1'b0; end
            else begin
                if (!dev(k-2) && !dev(k+2)) held = c;
                raw = map_ctl(held);
            end
            d = 2 * ones(raw) - 20;
            if (data && rd != 0 && d != 0 && ((rd > 0) == (d > 0))) begin
                exp_w[j] = ~raw;
                rd -= d;
            end else begin
                exp_w[j] = raw;
                rd += d;
            end
        end
    endtask

    task automatic run_slot(input logic de, input logic [17:0] v, input logic [8:0] c,
                            input logic [19:0] exp, input string req);
        logic [19:0] got;
        @(negedge clk);
        de_in = de; vid_in = v; ctl_in = c;
        for (int b = 0; b < 20; b++) begin
            bit_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bit_en = 1'b0;
            if (b == 0) begin
                check(word_out == exp, req, word_out, exp);
                check(word_start == 1'b1, "R7 word_start at bit 0", 20'(word_start), 20'h1);
                // R9: scramble inputs between boundaries
                de_in = ~de; vid_in = ~v; ctl_in = ~c;
            end
            if (b == 1) check(word_start == 1'b0, "R7 word_start after bit 0", 20'(word_start), 20'h0);
            got[b] = ser_out;
            @(posedge clk);
            @(negedge clk);
        end
        check(got == exp, "R7 serial order", got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [19:0] hw;
        logic hs, hst;
        build_expected();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(word_out == '0 && !ser_out && !word_start, "R8 reset state", word_out, '0);
        rst = 1'b0;

        for (int j = 0; j < NS; j++) begin
            if (j < NV)
                run_slot(VEC[j][27], VEC[j][26:9], VEC[j][8:0], exp_w[j], "R6 word R1 R2 R3 R4 R5 R9");
            else
                run_slot(1'b0, '0, '0, exp_w[j], "R6 flush word R2 R3 R5");
        end

        // R7: outputs hold while bit_en stays low
        @(negedge clk);
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        hw = word_out; hs = ser_out; hst = word_start;
        repeat (12) begin
            @(negedge clk);
            de_in = ~de_in; vid_in = ~vid_in;
        end
        check(word_out == hw && ser_out == hs && word_start == hst,
              "R7 hold without bit_en", word_out, hw);

        // R8: mid-stream reset clears state and disparity
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(word_out == '0 && !ser_out && !word_start, "R8 reset mid-stream", word_out, '0);
        rst = 1'b0;
        run_slot(1'b0, '0, 9'h0F5, 20'h00000, "R8 first word after reset");
        run_slot(1'b0, '0, 9'h0F5, 20'hFFFFF, "R3 inversion after reset");
        run_slot(1'b0, '0, 9'h0F5, map_ctl(9'h0F5), "R2 R5 sample after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule